// File: doc/BRIEF.md
# Multi-Width Leading Zero Counter

This unit takes a 64-bit source word and a two-bit width code. It reports how many zero bits sit above the highest set bit inside the selected width. The width can be 16, 32 or 64 bits and is chosen on every transaction. Only the low bits of the source that fall inside the chosen width are looked at.

Along with the count, the unit returns two flags. The carry flag marks an examined field that is entirely zero, in which case the count equals the width. The zero flag marks a count of zero, which means the top examined bit is set. Four further arithmetic flag outputs have no defined meaning for this operation. They are tied low and carry no information.

The count is produced by a logarithmic merge tree. By default a single output register stage follows the tree, and a valid bit travels alongside the data.

Top module: `lzc_unit`

## Requirements
- R1: The width code `in_size` selects the examined width: 2'b00 selects 16 bits, 2'b01 selects 32 bits, 2'b10 selects 64 bits, and 2'b11 also selects 64 bits.
- R2: The count is the number of consecutive zero bits found when scanning from bit (width-1) down toward bit 0, stopping at the first one bit.
- R3: When every examined bit is zero, the count equals the selected width (16, 32 or 64).
- R4: `out_cf` is 1 when every examined bit is zero and 0 otherwise.
- R5: `out_zf` is 1 when the count is 0, meaning bit (width-1) of the source is set, and 0 otherwise.
- R6: Source bits at or above the selected width have no effect on the count or the flags.
- R7: The count is given zero-extended on 7 bits, so that a count of 64 is reported as 7'd64.
- R8: With the register stage enabled, `out_valid` equals the value `in_valid` had one clock earlier. The result and flags belong to the operand presented in that earlier cycle. While `in_valid` is low, the previously reported count and flags are held.
- R9: While reset is asserted and directly after it, `out_valid`, `out_count`, `out_cf` and `out_zf` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_src | input | 64 | Source word |
| in_size | input | 2 | Width code (00=16, 01=32, 10/11=64) |
| out_valid | output | 1 | Result valid |
| out_count | output | 7 | Leading zero count |
| out_cf | output | 1 | Examined field was all zero |
| out_zf | output | 1 | Count is zero |
| out_of | output | 1 | Undefined flag, tied to 0 |
| out_sf | output | 1 | Undefined flag, tied to 0 |
| out_pf | output | 1 | Undefined flag, tied to 0 |
| out_af | output | 1 | Undefined flag, tied to 0 |

## Verification
The assertions assume a synchronous reset that is held for at least one clock edge. They also assume that `in_src` and `in_size` are stable around the rising edge whenever `in_valid` is high, and that all four width codes, including the reserved one, are legal inputs. The stimulus changes inputs only on the falling clock edge and drives only defined values. It covers every width code with the all-zero field, every one-hot position within the width, and random words. Some of those words have nonzero noise above the width, and idle cycles are mixed in so the hold behaviour is exercised.

// File: rtl/lzc_pkg.sv
package lzc_pkg;

    localparam int SRC_W  = 64;
    localparam int NARROW = 16;
    localparam int MEDIUM = 32;
    localparam int CNT_W  = $clog2(SRC_W) + 1;

    typedef enum logic [1:0] {
        SZ_16  = 2'b00,
        SZ_32  = 2'b01,
        SZ_64  = 2'b10,
        SZ_RSV = 2'b11
    } opsize_e;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] count;
        logic             cf;
        logic             zf;
    } lzc_state_t;

endpackage

// File: rtl/lzc_align.sv
// Places the examined field at the top of a full-width word and plants a
// sentinel one just below it, so a single tree serves every width and an
// all-zero narrow field naturally counts to its own width.
module lzc_align
    import lzc_pkg::*;
(
    input  logic [SRC_W-1:0] src,
    input  opsize_e          size,
    output logic [SRC_W-1:0] aligned,
    output logic             field_zero
);

    always_comb begin
        aligned    = '0;
        field_zero = 1'b0;
        unique case (size)
            SZ_16: begin
                aligned[SRC_W-1 -: NARROW] = src[NARROW-1:0];
                aligned[SRC_W-1-NARROW]    = 1'b1;
                field_zero                 = ~|src[NARROW-1:0];
            end
            SZ_32: begin
                aligned[SRC_W-1 -: MEDIUM] = src[MEDIUM-1:0];
                aligned[SRC_W-1-MEDIUM]    = 1'b1;
                field_zero                 = ~|src[MEDIUM-1:0];
            end
            default: begin
                aligned    = src;
                field_zero = ~|src;
            end
        endcase
    end

endmodule

// File: rtl/lzc_tree.sv
// Log-depth leading zero tree: each level merges adjacent node pairs.
// A node holds "has a one" and "zeros above its first one".
module lzc_tree #(
    parameter int W = 64
) (
    input  logic [W-1:0]         vec,
    output logic                 found,
    output logic [$clog2(W)-1:0] zeros
);

    localparam int LVLS = $clog2(W);
    localparam int CW   = LVLS;

    logic          hv_d [W];
    logic [CW-1:0] hc_d [W];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            hv_d[i] = vec[i];
            hc_d[i] = '0;
        end
        for (int lv = 1; lv <= LVLS; lv++) begin
            for (int j = 0; j < (W >> lv); j++) begin
                if (hv_d[2*j+1]) begin
                    hv_d[j] = 1'b1;
                    hc_d[j] = hc_d[2*j+1];
                end else begin
                    hv_d[j] = hv_d[2*j];
                    hc_d[j] = (CW'(1) << (lv - 1)) | hc_d[2*j];
                end
            end
        end
        found = hv_d[0];
        zeros = hc_d[0];
    end

endmodule

// File: rtl/lzc_unit.sv
module lzc_unit
    import lzc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_src,
    input  logic [1:0]       in_size,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_count,
    output logic             out_cf,
    output logic             out_zf,
    output logic             out_of,
    output logic             out_sf,
    output logic             out_pf,
    output logic             out_af
);

    localparam int TW = $clog2(SRC_W);

    logic [SRC_W-1:0] aligned;
    logic             field_zero;
    logic             found;
    logic [TW-1:0]    zeros;
    logic [CNT_W-1:0] count_c;
    lzc_state_t       st_d;
    lzc_state_t       st_q;

    lzc_align u_align (
        .src        (in_src),
        .size       (opsize_e'(in_size)),
        .aligned    (aligned),
        .field_zero (field_zero)
    );

    lzc_tree #(.W(SRC_W)) u_tree (
        .vec   (aligned),
        .found (found),
        .zeros (zeros)
    );

    always_comb begin
        count_c  = found ? {1'b0, zeros} : CNT_W'(SRC_W);
        st_d     = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.count = count_c;
            st_d.cf    = field_zero;
            st_d.zf    = (count_c == '0);
        end
    end

    assign out_of = 1'b0;
    assign out_sf = 1'b0;
    assign out_pf = 1'b0;
    assign out_af = 1'b0;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign out_valid = st_q.valid;
            assign out_count = st_q.count;
            assign out_cf    = st_q.cf;
            assign out_zf    = st_q.zf;

            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid); // R8
            AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid); // R8
            AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(out_count) && $stable(out_cf) && $stable(out_zf))); // R8
            AST_NARROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_size == SZ_16) |=> out_count <= CNT_W'(NARROW)); // R1
            AST_MEDIUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_size == SZ_32) |=> out_count <= CNT_W'(MEDIUM)); // R1
            AST_CF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_cf) |-> (out_count == CNT_W'(NARROW) ||
                                           out_count == CNT_W'(MEDIUM) ||
                                           out_count == CNT_W'(SRC_W))); // R4
            AST_CF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && !out_cf) |-> out_count < CNT_W'(SRC_W)); // R4
            AST_ZF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_zf == (out_count == '0))); // R5
            AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> !(out_zf && out_cf)); // R4 R5
        end else begin : g_comb
            assign st_q      = '0;
            assign out_valid = st_d.valid;
            assign out_count = st_d.count;
            assign out_cf    = st_d.cf;
            assign out_zf    = st_d.zf;
        end
    endgenerate

endmodule

// File: tb/lzc_unit_bench.sv
module lzc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_src = '0;
    logic [1:0]  in_size = 2'b00;
    logic        out_valid;
    logic [6:0]  out_count;
    logic        out_cf, out_zf, out_of, out_sf, out_pf, out_af;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic       exp_valid = 1'b0;
    int         exp_count = 0;
    logic       exp_cf = 1'b0;
    logic       exp_zf = 1'b0;
    string      exp_tag = "R8";

    always #10 clk = ~clk;

    lzc_unit u_lzc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_size(in_size), .out_valid(out_valid), .out_count(out_count),
        .out_cf(out_cf), .out_zf(out_zf), .out_of(out_of), .out_sf(out_sf),
        .out_pf(out_pf), .out_af(out_af)
    );

    function automatic int width_of(logic [1:0] z);
        return (z == 2'b00) ? 16 : (z == 2'b01) ? 32 : 64;
    endfunction

    function automatic int ref_count(logic [63:0] s, logic [1:0] z);
        int n = 0;
        for (int b = width_of(z) - 1; b >= 0; b--) begin
            if (s[b]) break;
            n++;
        end
        return n;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compares the previous cycle's expectation, then drives a new operand.
    task automatic step(logic v, logic [63:0] s, logic [1:0] z, string tag);
        int c;
        @(negedge clk);
        check({"R8 valid ", exp_tag}, int'(out_valid), int'(exp_valid));
        if (exp_valid) begin
            check({"R2 count ", exp_tag}, int'(out_count), exp_count);
            check({"R4 cf ", exp_tag}, int'(out_cf), int'(exp_cf));
            check({"R5 zf ", exp_tag}, int'(out_zf), int'(exp_zf));
        end else begin
            check({"R8 hold ", exp_tag}, int'(out_count), exp_count);
        end
        in_valid = v;
        in_src   = s;
        in_size  = z;
        exp_valid = v;
        exp_tag   = tag;
        if (v) begin
            c = ref_count(s, z);
            exp_count = c;
            exp_cf    = (c == width_of(z));
            exp_zf    = (c == 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 valid", int'(out_valid), 0);
        check("R9 count", int'(out_count), 0);
        check("R9 cf", int'(out_cf), 0);
        check("R9 zf", int'(out_zf), 0);
        rst_n = 1'b1;

        for (int z = 0; z < 4; z++) begin
            step(1'b1, 64'h0, 2'(z), "R3 R7 all-zero");
            step(1'b1, {64{1'b1}} << width_of(2'(z)) == 64'h0 ? 64'h0 :
                       ({64{1'b1}} << width_of(2'(z))), 2'(z), "R6 high noise zero field");
            for (int b = 0; b < width_of(2'(z)); b++)
                step(1'b1, 64'h1 << b, 2'(z), (z == 3) ? "R1 reserved one-hot" : "R2 one-hot");
            step(1'b0, 64'hFFFF, 2'(z), "R8 idle");
            step(1'b0, 64'h0, 2'(z), "R8 idle");
        end

        for (int i = 0; i < 600; i++) begin
            r = {$urandom, $urandom};
            r = r >> ($urandom % 64);
            if ((i % 3) == 0) r = r | (64'hF0F0_0000_0000_0000 >> (i % 17));
            step((i % 7) != 3, r, 2'($urandom % 4), "R6 random");
        end
        step(1'b0, 64'h0, 2'b00, "R8 drain");
        step(1'b0, 64'h0, 2'b00, "R8 drain");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule